// File: doc/BRIEF.md
# RTC Wake and Kickstart Power Sequencer

This block decides when a battery-backed real-time clock asks for system power. Two events can start a request. The first is a kickstart button that pulls an input low. The second is a one-cycle strobe from the calendar alarm comparator. When an enabled event arrives, the block pulls its open-drain power-request line low and latches a cause flag. It then gives the main supply a fixed number of cycles to report itself valid.

If the supply comes up within that window, three things happen. The request line stays low, the power-down control bit clears itself, and the open-drain interrupt line is pulled low to report the cause. If the window runs out first, the request line is released and the cause flag stays latched, so software can read it on a later power-on. Once the system is running, software clears flags by writing zeros. It shuts power down by setting the power-down bit. While the supply is valid, a fresh enabled event always pulls the request line low again.

Top module: `rtc_pwr_sequencer`

## Requirements
- R1: After reset both drive-low outputs are inactive, both flags are 0, the wake and kickstart enables are 0 and the power-down bit is 1.
- R2: With the kickstart enable set, a low level on the kickstart pin lasting at least KS_MIN_CYC clock cycles sets the kickstart flag (status bit 1) and drives the power-request output. A shorter low pulse changes neither.
- R3: With the kickstart enable clear, a qualifying kickstart pulse leaves the flag at 0 and the power-request output inactive.
- R4: An alarm strobe always sets the wake flag (status bit 0). It drives the power-request output only when the wake enable (control bit 0) is 1.
- R5: When supply-valid has not asserted within PON_TIMEOUT_CYC cycles of a request, the power-request output is released. The interrupt output stays inactive, the cause flag stays 1 and the power-down bit stays 1.
- R6: When supply-valid asserts during a request, the power-request output stays driven and the power-down bit (control bit 2) reads 0. The interrupt output is driven when an enabled flag is set.
- R7: While powered on, the power-request output stays driven for as long as the power-down bit is 0. Writing 1 to the power-down bit releases it.
- R8: Writing 0 to a status bit clears that flag; writing 1 leaves it unchanged. The interrupt output is driven only while the supply is valid and either an enabled flag or the external pending-interrupt input is set.
- R9: In the power-down-pending state with the supply still valid, an enabled event drives the power-request output again, and the power-on completes as in R6.
- R10: The interrupt output is inactive in any cycle after one in which supply-valid was low.
- R11: Register map: address 0 is status (bit 1 kickstart flag, bit 0 wake flag), address 1 is control (bit 2 power-down, bit 1 kickstart enable, bit 0 wake enable). Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on slow clock |
| rst | input | 1 | Synchronous active-high reset |
| ks_pin_n | input | 1 | Asynchronous kickstart pin, active low |
| alarm_match | input | 1 | One-cycle strobe from the calendar alarm comparator |
| supply_ok | input | 1 | Main supply valid |
| ext_irq_pending | input | 1 | Another interrupt source in the clock is pending |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 3 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 3 | Register read data, combinational |
| pwr_drive_low | output | 1 | Enable for pulling the power-request line low |
| irq_drive_low | output | 1 | Enable for pulling the interrupt line low |

## Verification
The bench drives three kickstart patterns. A pulse one cycle shorter than the minimum width against a long pulse shows whether qualification counts correctly. The same long pulse with the enable cleared shows whether the enable gates it. It also drives alarm strobes with the wake enable off and on, which tells flag setting apart from the power request. Three supply patterns separate the outcomes of a request: the supply never arrives, the supply arrives inside the window, and the supply is already present in the power-down-pending state. Flag writes of ones and zeros, and toggling the external pending input, show which sources keep the interrupt line active.

// File: rtl/rtcpwr_pkg.sv
package rtcpwr_pkg;

    localparam int REG_W  = 3;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_STATUS = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd1;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_REQ  = 2'd1,
        SQ_ON   = 2'd2,
        SQ_PDN  = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic kf;
        logic wf;
    } flags_t;

    typedef struct packed {
        logic pab;
        logic kse;
        logic wie;
    } ctrl_t;

    function automatic logic [REG_W-1:0] pack_status(input flags_t f);
        return {1'b0, f};
    endfunction

    function automatic logic [REG_W-1:0] pack_ctrl(input ctrl_t c);
        return c;
    endfunction

endpackage

// File: rtl/ks_qualifier.sv
module ks_qualifier #(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_CYC     = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic pulse_o
);
    localparam int CW = $clog2(MIN_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(MIN_CYC - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          cnt_q;
    logic                   armed_q;
    logic                   pin_s;
    logic                   hit;

    // Pin idles high, so the chain resets to ones.
    always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
    end

    assign pin_s = sync_q[SYNC_STAGES-1];
    assign hit   = !pin_s && armed_q && (cnt_q == LAST);

    // Arms on a high level; counts consecutive low cycles after that.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else if (pin_s) begin
            cnt_q   <= '0;
            armed_q <= 1'b1;
        end else if (armed_q) begin
            if (hit) begin
                cnt_q   <= '0;
                armed_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign pulse_o = hit;
endmodule

// File: rtl/pon_timer.sv
module pon_timer #(
    parameter int LIMIT = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic expired_o
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    assign expired_o = run_i && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run_i) cnt_q <= '0;
        else if (!expired_o) cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import rtcpwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       trig_i,
    input  logic       supply_ok_i,
    input  logic       expired_i,
    input  logic       pab_i,
    output seq_state_e state_o,
    output logic       success_o,
    output logic       timer_run_o
);
    seq_state_e state_q, state_d;

    always_comb begin
        state_d   = state_q;
        success_o = 1'b0;
        unique case (state_q)
            SQ_IDLE: if (trig_i) state_d = SQ_REQ;
            SQ_REQ: begin
                if (supply_ok_i) begin
                    state_d   = SQ_ON;
                    success_o = 1'b1;
                end else if (expired_i) begin
                    state_d = SQ_IDLE;
                end
            end
            SQ_ON:   if (pab_i) state_d = SQ_PDN;
            SQ_PDN: begin
                if (trig_i)            state_d = SQ_REQ;
                else if (!supply_ok_i) state_d = SQ_IDLE;
            end
            default: state_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SQ_IDLE;
        else     state_q <= state_d;
    end

    assign state_o     = state_q;
    assign timer_run_o = (state_q == SQ_REQ);
endmodule

// File: rtl/rtc_pwr_sequencer.sv
module rtc_pwr_sequencer
    import rtcpwr_pkg::*;
#(
    parameter int KS_MIN_CYC      = 4,
    parameter int PON_TIMEOUT_CYC = 32,
    parameter int SYNC_STAGES     = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ks_pin_n,
    input  logic              alarm_match,
    input  logic              supply_ok,
    input  logic              ext_irq_pending,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    output logic              pwr_drive_low,
    output logic              irq_drive_low
);
    flags_t     flags_q;
    ctrl_t      ctrl_q;
    seq_state_e state;
    logic       ks_pulse, ks_evt, wake_evt, trig;
    logic       expired, success, timer_run;
    logic       wr_status, wr_ctrl, irq_q;

    ks_qualifier #(.SYNC_STAGES(SYNC_STAGES), .MIN_CYC(KS_MIN_CYC)) u_ksq (
        .clk(clk), .rst(rst), .pin_n(ks_pin_n), .pulse_o(ks_pulse)
    );

    pon_timer #(.LIMIT(PON_TIMEOUT_CYC)) u_tmr (
        .clk(clk), .rst(rst), .run_i(timer_run), .expired_o(expired)
    );

    seq_fsm u_fsm (
        .clk(clk), .rst(rst), .trig_i(trig), .supply_ok_i(supply_ok),
        .expired_i(expired), .pab_i(ctrl_q.pab), .state_o(state),
        .success_o(success), .timer_run_o(timer_run)
    );

    assign ks_evt    = ks_pulse && ctrl_q.kse;
    assign wake_evt  = alarm_match && ctrl_q.wie;
    assign trig      = ks_evt || wake_evt;
    assign wr_status = wr_en && (wr_addr == ADDR_STATUS);
    assign wr_ctrl   = wr_en && (wr_addr == ADDR_CTRL);

    // Flags: a write of 0 clears, a write of 1 keeps; a new event wins.
    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            flags_q.wf <= alarm_match || (flags_q.wf && !(wr_status && !wr_data[0]));
            flags_q.kf <= ks_evt      || (flags_q.kf && !(wr_status && !wr_data[1]));
        end
    end

    // Control: the automatic power-down clear on success has priority.
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '{pab: 1'b1, kse: 1'b0, wie: 1'b0};
        end else begin
            if (wr_ctrl) ctrl_q <= ctrl_t'(wr_data);
            if (success) ctrl_q.pab <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= supply_ok && ((flags_q.wf && ctrl_q.wie) ||
                                        (flags_q.kf && ctrl_q.kse) ||
                                        ext_irq_pending);
    end

    always_comb begin
        unique case (rd_addr)
            ADDR_STATUS: rd_data = pack_status(flags_q);
            ADDR_CTRL:   rd_data = pack_ctrl(ctrl_q);
            default:     rd_data = '0;
        endcase
    end

    assign pwr_drive_low = (state == SQ_REQ) || (state == SQ_ON);
    assign irq_drive_low = irq_q;
endmodule

// File: rtl/rtcpwr_checker.sv
module rtcpwr_checker
    import rtcpwr_pkg::*;
#(
    parameter int PON_TIMEOUT_CYC = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              alarm_match,
    input logic              supply_ok,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [REG_W-1:0]  wr_data,
    input logic              trig,
    input seq_state_e        state,
    input logic              wf,
    input logic              kf,
    input logic              pab,
    input logic              pwr_drive_low,
    input logic              irq_drive_low
);
    int req_cycles;

    always_ff @(posedge clk) begin
        if (rst || state != SQ_REQ) req_cycles <= 0;
        else                        req_cycles <= req_cycles + 1;
    end

    AST_REQ_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_REQ) |-> (req_cycles < PON_TIMEOUT_CYC)); // R5

    AST_IDLE_TRIG_DRIVES: assert property (@(posedge clk) disable iff (rst)
        (trig && state == SQ_IDLE) |=> pwr_drive_low); // R2

    AST_IRQ_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (rst)
        irq_drive_low |-> $past(supply_ok)); // R10

    AST_WF_SET_BY_ALARM: assert property (@(posedge clk) disable iff (rst)
        $rose(wf) |-> $past(alarm_match)); // R4

    AST_KF_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
        $fell(kf) |-> $past(wr_en && wr_addr == ADDR_STATUS && !wr_data[1])); // R8

    AST_PAB_FALL_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $fell(pab) |-> ($past(state == SQ_REQ && supply_ok) ||
                        $past(wr_en && wr_addr == ADDR_CTRL && !wr_data[2]))); // R6
endmodule

bind rtc_pwr_sequencer rtcpwr_checker #(.PON_TIMEOUT_CYC(PON_TIMEOUT_CYC)) u_chk (
    .clk(clk), .rst(rst), .alarm_match(alarm_match), .supply_ok(supply_ok),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .trig(trig),
    .state(state), .wf(flags_q.wf), .kf(flags_q.kf), .pab(ctrl_q.pab),
    .pwr_drive_low(pwr_drive_low), .irq_drive_low(irq_drive_low)
);

// File: tb/rtc_pwr_sequencer_bench.sv
`timescale 1ns/100ps
module rtc_pwr_sequencer_bench;
    localparam int KS_MIN  = 4;
    localparam int TIMEOUT = 32;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ks_pin_n = 1'b1, alarm_match = 1'b0, supply_ok = 1'b0, ext_irq = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0, rd_addr = '0;
    logic [2:0] wr_data = '0, rd_data;
    logic       pwr_drive_low, irq_drive_low;

    int checks = 0, errors = 0;
    bit done = 0;

    typedef struct {
        string      req;
        logic       pwr;
        logic       irq;
        logic [2:0] st;
        logic [2:0] ct;
    } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    rtc_pwr_sequencer #(.KS_MIN_CYC(KS_MIN), .PON_TIMEOUT_CYC(TIMEOUT), .SYNC_STAGES(2))
    u_rtc_pwr_sequencer (
        .clk(clk), .rst(rst), .ks_pin_n(ks_pin_n), .alarm_match(alarm_match),
        .supply_ok(supply_ok), .ext_irq_pending(ext_irq), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pwr_drive_low(pwr_drive_low), .irq_drive_low(irq_drive_low)
    );

    task automatic expect_item(input string req, input logic pwr, input logic irq,
                               input logic [2:0] st, input logic [2:0] ct);
        exp_t e;
        e.req = req; e.pwr = pwr; e.irq = irq; e.st = st; e.ct = ct;
        exp_q.push_back(e);
        @(negedge clk);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [2:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic ks_pulse(input int low_cycles);
        ks_pin_n = 1'b0;
        step(low_cycles);
        ks_pin_n = 1'b1;
    endtask

    task automatic alarm_pulse();
        alarm_match = 1'b1;
        @(negedge clk);
        alarm_match = 1'b0;
    endtask

    // Monitor: pops expectations and compares them with port values mid-cycle.
    initial begin
        forever begin
            @(negedge clk);
            #0.5;
            while (exp_q.size() > 0) begin
                exp_t e;
                logic [2:0] st, ct, un;
                e = exp_q.pop_front();
                rd_addr = 2'd0; #0.1; st = rd_data;
                rd_addr = 2'd1; #0.1; ct = rd_data;
                rd_addr = 2'd2; #0.1; un = rd_data;
                checks++;
                if (pwr_drive_low !== e.pwr || irq_drive_low !== e.irq ||
                    st !== e.st || ct !== e.ct || un !== 3'd0) begin
                    errors++;
                    $display("FAIL %s: actual pwr=%b irq=%b st=%h ct=%h unused=%h expected pwr=%b irq=%b st=%h ct=%h unused=0",
                             e.req, pwr_drive_low, irq_drive_low, st, ct, un,
                             e.pwr, e.irq, e.st, e.ct);
                end
            end
        end
    end

    initial begin
        step(4);
        rst = 1'b0;
        step(2);
        expect_item("R1 reset", 0, 0, 3'h0, 3'h4);
        expect_item("R11 map after reset", 0, 0, 3'h0, 3'h4);

        ks_pulse(10); step(6);
        expect_item("R3 kickstart disabled", 0, 0, 3'h0, 3'h4);

        reg_write(2'd1, 3'h6);
        ks_pulse(KS_MIN - 1); step(6);
        expect_item("R2 short pulse ignored", 0, 0, 3'h0, 3'h6);

        ks_pulse(KS_MIN + 2); step(3);
        expect_item("R2 qualified kickstart", 1, 0, 3'h2, 3'h6);

        step(TIMEOUT + 8);
        expect_item("R5 timeout releases", 0, 0, 3'h2, 3'h6);

        reg_write(2'd0, 3'h3);
        expect_item("R8 write ones keep", 0, 0, 3'h2, 3'h6);
        reg_write(2'd0, 3'h0);
        expect_item("R8 write zero clears", 0, 0, 3'h0, 3'h6);

        alarm_pulse(); step(2);
        expect_item("R4 wake flag without enable", 0, 0, 3'h1, 3'h6);
        reg_write(2'd0, 3'h0);

        reg_write(2'd1, 3'h7);
        alarm_pulse(); step(3);
        expect_item("R4 wake request", 1, 0, 3'h1, 3'h7);
        supply_ok = 1'b1; step(3);
        expect_item("R6 successful power-on", 1, 1, 3'h1, 3'h3);

        reg_write(2'd0, 3'h0); step(1);
        expect_item("R8 irq released after clear", 1, 0, 3'h0, 3'h3);
        ext_irq = 1'b1; step(2);
        expect_item("R8 other source holds irq", 1, 1, 3'h0, 3'h3);
        ext_irq = 1'b0; step(2);

        step(TIMEOUT + 18);
        expect_item("R7 held while power-down bit 0", 1, 0, 3'h0, 3'h3);
        reg_write(2'd1, 3'h7); step(1);
        expect_item("R7 power-down releases", 0, 0, 3'h0, 3'h7);

        ks_pulse(KS_MIN + 2); step(4);
        expect_item("R9 event while supply valid", 1, 1, 3'h2, 3'h3);

        reg_write(2'd1, 3'h7); step(1);
        supply_ok = 1'b0; step(3);
        expect_item("R10 irq released on supply loss", 0, 0, 3'h2, 3'h7);

        step(3);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL ALL: watchdog expired, actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule